// File: doc/BRIEF.md
# Segmented Converter Input Path

This block is the digital front end of a 12-bit current-steering converter whose switch array is split in two. A parallel input word is taken in by a master register on each rising clock edge and moved into a slave register one edge later. The slave register sits directly in front of the switch drivers, so every switch control changes on the same edge. The eight low bits drive a binary-weighted ladder section unchanged. The four high bits are decoded into fifteen unary segment enables.

Because only the high nibble is decoded, the largest switching event happens at each 256-code boundary and not once at mid scale. The block raises a one-cycle flag whenever the word shown at the outputs has a different high nibble from the word shown before it. It also carries a digital model of the two complementary current outputs: the main output equals the code, and the complementary output equals full scale minus one LSB minus the code. The model is used for verification and system-level checks.

Top module: `segdac_front`

## Requirements
- R1: A word presented on `din` before rising edge n appears on every output after rising edge n+1, which is two edges of latency. A new word can be accepted on every clock.
- R2: Reset is synchronous and active low. It clears both register stages. While it is held, and on the first edge after release, `bin_sw`, `seg_en`, `out_main` and `seg_carry` are zero and `out_comp` is 4095.
- R3: `bin_sw[i]` equals bit i of the captured word for i from 0 to 7.
- R4: `seg_en[k]` is 1 exactly when the unsigned value of bits 11:8 of the captured word is greater than k, for k from 0 to 14. Code 0 enables no segments and code 15 enables all fifteen.
- R5: The number of ones in `seg_en` equals the value of bits 11:8, and the ones always form a contiguous run that starts at bit 0.
- R6: `out_main` equals the captured 12-bit word. It is zero for code 0x000, 2048 for code 0x800 and 4095 for code 0xFFF.
- R7: `out_comp` equals 4095 minus the captured word, so `out_main + out_comp` is always 4095.
- R8: `seg_carry` is 1 for exactly the cycle in which the outputs show a word whose bits 11:8 differ from those of the previously shown word (zero after reset). Otherwise it is 0, including across a 255-to-254 step or any other step that stays inside one 256-code band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 12 | Parallel input word, bit 11 most significant |
| bin_sw | output | 8 | Binary-weighted ladder switch controls |
| seg_en | output | 15 | Thermometer-coded segment enables, bit 0 first to turn on |
| out_main | output | 12 | Model of the main output magnitude in LSB |
| out_comp | output | 12 | Model of the complementary output magnitude in LSB |
| seg_carry | output | 1 | Pulse marking a change of the high nibble at the outputs |

## Verification
The hardest case to reach is a carry flag that must stay low while the low byte wraps, as in steps like 0x2FF to 0x2FE or repeated words inside one band. The flag must also rise on every boundary crossing, including steps to the same low byte in a different band. The stimulus walks across every 256-code boundary in both directions, holds words inside one band, and then feeds random back-to-back words. Reset is asserted once in the middle of a run while `din` is non-zero, so the clearing of both stages shows on the outputs over the two edges that follow.

// File: rtl/segdac_pkg.sv
// Package: segdac_pkg
// Shared default sizes and arithmetic helpers for the segmented converter
// front end. Assumes the word splits into a binary low part and a unary
// high part with the high part no wider than a few bits.
package segdac_pkg;
    localparam int DEF_WORD_W = 12;
    localparam int DEF_BIN_W  = 8;

    // Number of unary segments for a decoded field of the given width.
    function automatic int seg_count(input int hi_bits);
        return (1 << hi_bits) - 1;
    endfunction
endpackage

// File: rtl/segdac_master.sv
// Module: segdac_master
// First capture stage. Takes the raw input word on each rising edge.
// Assumes the input meets setup and hold to clk; no handshake.
module segdac_master #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] word_q
);
    // Capture the input word, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= din;
    end
endmodule

// File: rtl/segdac_therm.sv
// Module: segdac_therm
// Unsigned binary to thermometer decoder. Output k is high when the
// input value exceeds k. Purely combinational; assumes SEG_N = 2**HI_W-1.
module segdac_therm #(
    parameter int HI_W  = 4,
    parameter int SEG_N = 15
) (
    input  logic [HI_W-1:0]  code,
    output logic [SEG_N-1:0] therm
);
    // One comparator per segment.
    for (genvar k = 0; k < SEG_N; k++) begin : g_seg
        assign therm[k] = (int'(code) > k);
    end
endmodule

// File: rtl/segdac_slave.sv
// Module: segdac_slave
// Second register stage in front of the switch drivers. Registers binary
// switches, segment enables, output models and the band-change flag so
// that all of them move on one edge. Assumes the master word and its
// decoded segments arrive together.
module segdac_slave #(
    parameter int WORD_W = 12,
    parameter int BIN_W  = 8,
    parameter int SEG_N  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] m_word,
    input  logic [SEG_N-1:0]  m_seg,
    output logic [BIN_W-1:0]  bin_q,
    output logic [SEG_N-1:0]  seg_q,
    output logic [WORD_W-1:0] main_q,
    output logic [WORD_W-1:0] comp_q,
    output logic              carry_q
);
    localparam int          HI_W    = WORD_W - BIN_W;
    localparam logic [WORD_W-1:0] FS_M1 = {WORD_W{1'b1}};

    // Move the decoded word to the switch controls and update the models.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q   <= '0;
            seg_q   <= '0;
            main_q  <= '0;
            comp_q  <= FS_M1;
            carry_q <= 1'b0;
        end else begin
            bin_q   <= m_word[BIN_W-1:0];
            seg_q   <= m_seg;
            main_q  <= m_word;
            comp_q  <= FS_M1 - m_word;
            carry_q <= (m_word[WORD_W-1 -: HI_W] != main_q[WORD_W-1 -: HI_W]);
        end
    end

    // Tracks cycles since reset so past-value checks stay inside them.
    logic warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    // R5: segment enables form a contiguous run from bit 0 of the right length.
    assert_therm_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((seg_q & (seg_q + 1'b1)) == '0) &&
        ($countones(seg_q) == int'(main_q[WORD_W-1 -: HI_W])));

    // R7: complementary model sums with the main model to full scale minus one.
    assert_comp_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, main_q} + {1'b0, comp_q}) == {1'b0, FS_M1});

    // R3: ladder switches follow the low byte of the shown word.
    assert_bin_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bin_q == main_q[BIN_W-1:0]);

    // R8: the flag marks exactly the cycles in which the segment set changed.
    assert_carry_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q |-> (carry_q == (seg_q != $past(seg_q))));
endmodule

// File: rtl/segdac_front.sv
// Module: segdac_front
// Top of the segmented converter input path: master capture, unary decode
// of the high field, slave stage in front of the switches. Assumes one word
// per clock and a synchronous active-low reset.
module segdac_front #(
    parameter int WORD_W = segdac_pkg::DEF_WORD_W,
    parameter int BIN_W  = segdac_pkg::DEF_BIN_W
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [WORD_W-1:0]                           din,
    output logic [BIN_W-1:0]                            bin_sw,
    output logic [segdac_pkg::seg_count(WORD_W-BIN_W)-1:0] seg_en,
    output logic [WORD_W-1:0]                           out_main,
    output logic [WORD_W-1:0]                           out_comp,
    output logic                                        seg_carry
);
    localparam int HI_W  = WORD_W - BIN_W;
    localparam int SEG_N = segdac_pkg::seg_count(HI_W);

    logic [WORD_W-1:0] m_word;
    logic [SEG_N-1:0]  m_seg;

    segdac_master #(.WORD_W(WORD_W)) u_master (
        .clk(clk), .rst_n(rst_n), .din(din), .word_q(m_word)
    );

    segdac_therm #(.HI_W(HI_W), .SEG_N(SEG_N)) u_therm (
        .code(m_word[WORD_W-1 -: HI_W]), .therm(m_seg)
    );

    segdac_slave #(.WORD_W(WORD_W), .BIN_W(BIN_W), .SEG_N(SEG_N)) u_slave (
        .clk(clk), .rst_n(rst_n), .m_word(m_word), .m_seg(m_seg),
        .bin_q(bin_sw), .seg_q(seg_en), .main_q(out_main),
        .comp_q(out_comp), .carry_q(seg_carry)
    );

    // Counts edges since reset release, saturating, for latency checks.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: outputs show the word sampled two edges earlier.
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_main == $past(din, 2)));

    // R4: segment enables match the unary value of the word sampled two edges ago.
    assert_seg_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |->
        ($countones(seg_en) == int'($past(din[WORD_W-1 -: HI_W], 2))));
endmodule

// File: tb/sim_segdac_front.sv
// Bench for segdac_front: behavioural queue model checked every cycle.
module sim_segdac_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] din = 12'h0;
    logic [7:0]  bin_sw;
    logic [14:0] seg_en;
    logic [11:0] out_main, out_comp;
    logic        seg_carry;

    int n_chk = 0;
    int n_fail = 0;
    int hist_w[$];
    bit hist_r[$];
    int prev_shown = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    segdac_front u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .bin_sw(bin_sw), .seg_en(seg_en),
        .out_main(out_main), .out_comp(out_comp), .seg_carry(seg_carry)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    // One cycle: check shown outputs against the model, then drive next input.
    task automatic step(input bit r, input int w);
        @(negedge clk);
        cyc++;
        if (hist_w.size() >= 2) begin
            int e;
            int hi;
            int exp_seg;
            bit in_rst;
            in_rst = hist_r[$] || hist_r[$-1];
            e  = hist_r[$] ? 0 : hist_w[$-1];
            hi = e >> 8;
            exp_seg = 0;
            for (int k = 0; k < 15; k++) if (hi > k) exp_seg |= (1 << k);
            if (in_rst) begin
                chk("R2 out_main", int'(out_main), 0);
                chk("R2 out_comp", int'(out_comp), 4095);
                chk("R2 seg_en", int'(seg_en), 0);
                chk("R2 bin_sw", int'(bin_sw), 0);
                chk("R2 seg_carry", int'(seg_carry), 0);
            end
            chk("R1 R6 out_main", int'(out_main), e);
            chk("R7 out_comp", int'(out_comp), 4095 - e);
            chk("R3 bin_sw", int'(bin_sw), e & 255);
            chk("R4 R5 seg_en", int'(seg_en), exp_seg);
            chk("R8 seg_carry", int'(seg_carry),
                (!hist_r[$] && ((e >> 8) != (prev_shown >> 8))) ? 1 : 0);
            prev_shown = e;
        end
        rst_n = !r;
        din   = 12'(w);
        hist_w.push_back(r ? 0 : w);
        hist_r.push_back(r);
    endtask

    initial begin
        #400000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R2: reset held with a non-zero input word.
        for (int i = 0; i < 4; i++) step(1'b1, 12'hABC);
        // R6 corner codes: zero, half scale, full scale.
        step(1'b0, 12'h000);
        step(1'b0, 12'h800);
        step(1'b0, 12'hFFF);
        step(1'b0, 12'h000);
        // R8: every 256-code boundary crossed upward and downward.
        for (int b = 1; b < 16; b++) begin
            step(1'b0, b * 256 - 1);
            step(1'b0, b * 256);
            step(1'b0, b * 256 - 1);
        end
        // R8: steps inside one band must not flag.
        for (int i = 0; i < 8; i++) step(1'b0, 12'h2FF - i);
        step(1'b0, 12'h2FE);
        step(1'b0, 12'h2FE);
        // R8: same low byte, different band.
        step(1'b0, 12'h355);
        step(1'b0, 12'h455);
        // R4 R5: every high-nibble value.
        for (int h = 0; h < 16; h++) step(1'b0, (h << 8) | (h * 17));
        // R2: mid-run reset with non-zero input, then release.
        step(1'b0, 12'h9A5);
        step(1'b1, 12'h7E1);
        step(1'b0, 12'h7E1);
        step(1'b0, 12'h123);
        // R1: random back-to-back words.
        for (int i = 0; i < 2000; i++) step(1'b0, int'($urandom_range(0, 4095)));
        step(1'b0, 0);
        step(1'b0, 0);
        step(1'b0, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule